// File: doc/BRIEF.md
# Punched-Tape Binary Image Loader

This block turns a stream of eight-bit tape frames, in the classic binary punched-tape layout, into writes of 12-bit words into a word memory with 15-bit addresses (eight fields of 4096 words). Bytes arrive one per accepted transfer on a valid/ready input. Each word is carried by two frames: a high frame holding six data bits plus an origin marker bit, then a low frame. Origin words move the load address, data words are written at the current field and origin, field-setting bytes change the upper three address bits, and rubout bytes cancel themselves and the byte after them.

The loader keeps a running sum of the frames it sees. A trailer frame in the place where a new high frame is expected marks the end of the tape. The word just completed is then taken as the checksum rather than written. The loader raises `done`, and raises `csum_err` if the sum disagrees. A write whose address falls outside the configured memory depth is dropped and raises a sticky `overflow`. A one-cycle `restart` pulse clears everything so that another tape can be loaded.

Top module: `tape_loader`

## Requirements
- R1: After reset or a `restart` pulse, `done`, `csum_err`, `overflow` and `wr_en` are 0, and field, origin and sum are all zero. `in_ready` is 1 except in a cycle where `restart` is high, and a byte offered in that cycle is not taken.
- R2: Before the first word begins (the leader), bytes 0 and 0200 (octal) are ignored. The first byte below 0200 other than 0 becomes the high frame of the first word.
- R3: A byte 0377 is a rubout. It and the byte accepted right after it are discarded, whatever their values, and change no state.
- R4: A word is built as (high << 6) | low from a high frame followed by a low frame. The word is treated as complete when the next non-trailer high frame is accepted.
- R5: A completed word with bit 12 (octal 010000) set is an origin word. Its low 12 bits become the origin, and no write takes place.
- R6: A completed word with bit 12 clear is written: `wr_data` carries its low 12 bits and `wr_addr` = field*4096 + origin. The origin then steps by one modulo 4096. `wr_en` is high for one cycle, in the cycle after the completing byte is accepted.
- R7: A byte from 0201 to 0376 sets a pending field equal to bits 5:3 of the byte. The field used for addresses takes this value only once the next word has completed, so that word still uses the previous field.
- R8: A byte 0200 accepted where a high frame is expected ends the tape and sets `done`. The word just built is then the checksum. `csum_err` is set when (sum of the high and low frame values of all earlier words, minus that word) mod 4096 is not zero.
- R9: While `done` is high, bytes are still accepted (`in_ready` = 1) but cause no write and change no state, until `restart`.
- R10: A data word whose address is at or beyond MEM_DEPTH is not written and sets `overflow`. `overflow` stays set until `restart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous clear for a new tape |
| in_valid | input | 1 | Tape byte offered |
| in_ready | output | 1 | Loader can take a byte |
| in_byte | input | 8 | Tape frame value |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 15 | Memory word address |
| wr_data | output | 12 | Memory write data |
| done | output | 1 | Trailer seen, load finished |
| csum_err | output | 1 | Checksum mismatch at trailer |
| overflow | output | 1 | A write fell outside the memory depth |

## Verification
The properties assume that `restart` is only raised as a short pulse between tapes, that `rst_n` is asserted at the start, and that `in_valid` may rise at any time because the loader never stalls except under `restart`. The sticky-flag and quiet-after-done properties rely on `restart` being the only way to clear state. The bench therefore drives every tape from reset or right after a single-cycle restart, and offers bytes back to back on falling edges. The tapes cover leader runs, a rubout whose victim is a trailer code, a field byte placed between two words, an origin word in mid-stream, origin wrap at 07777, a bad checksum and a field beyond the configured depth. Each tape's expected addresses, data and checksum are worked out arithmetically as it is built.

// File: rtl/tape_loader_pkg.sv
package tape_loader_pkg;

   localparam int BYTE_W  = 8;
   localparam int FRAME_W = 6;
   localparam int HI_W    = FRAME_W + 1;
   localparam int WORD_W  = 2 * FRAME_W;
   localparam int FIELD_W = 3;
   localparam int ADDR_W  = WORD_W + FIELD_W;

   localparam logic [BYTE_W-1:0] CODE_RUBOUT = 8'o377;
   localparam logic [BYTE_W-1:0] CODE_TRAIL  = 8'o200;
   localparam logic [BYTE_W-1:0] CODE_BLANK  = 8'o000;

   typedef enum logic [1:0] {
      ST_LEADER = 2'd0,
      ST_LOW    = 2'd1,
      ST_NEXT   = 2'd2,
      ST_DONE   = 2'd3
   } ld_state_e;

   typedef struct packed {
      logic rubout;
      logic field;
      logic blank;
      logic trail;
   } byte_class_t;

   function automatic logic [WORD_W:0] join_frames(input logic [HI_W-1:0] hi,
                                                   input logic [BYTE_W-1:0] lo);
      logic [WORD_W:0] hv;
      logic [WORD_W:0] lv;
      hv = {hi, {FRAME_W{1'b0}}};
      lv = {{(WORD_W+1-BYTE_W){1'b0}}, lo};
      return hv | lv;
   endfunction

endpackage

// File: rtl/tape_classify.sv
module tape_classify
   import tape_loader_pkg::*;
(
   input  logic [BYTE_W-1:0]  bval_i,
   output byte_class_t        cls_o,
   output logic [FIELD_W-1:0] fld_o
);

   always_comb begin
      cls_o.rubout = (bval_i == CODE_RUBOUT);
      cls_o.field  = (bval_i > CODE_TRAIL) && (bval_i != CODE_RUBOUT);
      cls_o.trail  = (bval_i == CODE_TRAIL);
      cls_o.blank  = (bval_i == CODE_BLANK) || (bval_i == CODE_TRAIL);
      fld_o        = bval_i[FRAME_W-1:FRAME_W-FIELD_W];
   end

endmodule

// File: rtl/tape_framer.sv
module tape_framer
   import tape_loader_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart_i,
   input  logic               take_i,
   input  logic [BYTE_W-1:0]  bval_i,
   input  byte_class_t        cls_i,
   input  logic [FIELD_W-1:0] fld_i,
   output logic               word_ev_o,
   output logic               is_org_o,
   output logic               trail_ev_o,
   output logic [WORD_W-1:0]  word_o,
   output logic [HI_W-1:0]    hi_o,
   output logic [BYTE_W-1:0]  lo_o,
   output logic [FIELD_W-1:0] field_o,
   output logic [WORD_W-1:0]  origin_o,
   output logic               done_o
);

   ld_state_e          st_q;
   logic               skip_q;
   logic [HI_W-1:0]    hi_q;
   logic [BYTE_W-1:0]  lo_q;
   logic [FIELD_W-1:0] pend_q;
   logic [FIELD_W-1:0] field_q;
   logic [WORD_W-1:0]  org_q;

   logic               live;
   logic               norm;
   logic [WORD_W:0]    word_c;

   always_comb begin
      live       = take_i && !skip_q && (st_q != ST_DONE);
      norm       = live && !cls_i.rubout && !cls_i.field;
      word_c     = join_frames(hi_q, lo_q);
      word_ev_o  = norm && (st_q == ST_NEXT) && !cls_i.trail;
      trail_ev_o = norm && (st_q == ST_NEXT) && cls_i.trail;
      is_org_o   = word_c[WORD_W];
      word_o     = word_c[WORD_W-1:0];
      hi_o       = hi_q;
      lo_o       = lo_q;
      field_o    = field_q;
      origin_o   = org_q;
      done_o     = (st_q == ST_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_LEADER;
         skip_q  <= 1'b0;
         hi_q    <= '0;
         lo_q    <= '0;
         pend_q  <= '0;
         field_q <= '0;
         org_q   <= '0;
      end else if (restart_i) begin
         st_q    <= ST_LEADER;
         skip_q  <= 1'b0;
         hi_q    <= '0;
         lo_q    <= '0;
         pend_q  <= '0;
         field_q <= '0;
         org_q   <= '0;
      end else begin
         if (take_i && skip_q && (st_q != ST_DONE))
            skip_q <= 1'b0;
         if (live && cls_i.rubout)
            skip_q <= 1'b1;
         if (live && cls_i.field)
            pend_q <= fld_i;
         if (norm) begin
            case (st_q)
               ST_LEADER: begin
                  if (!cls_i.blank) begin
                     hi_q <= bval_i[HI_W-1:0];
                     st_q <= ST_LOW;
                  end
               end
               ST_LOW: begin
                  lo_q <= bval_i;
                  st_q <= ST_NEXT;
               end
               ST_NEXT: begin
                  if (cls_i.trail) begin
                     st_q <= ST_DONE;
                  end else begin
                     if (word_c[WORD_W])
                        org_q <= word_c[WORD_W-1:0];
                     else
                        org_q <= org_q + 1'b1;
                     field_q <= pend_q;
                     hi_q    <= bval_i[HI_W-1:0];
                     st_q    <= ST_LOW;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/tape_checksum.sv
module tape_checksum
   import tape_loader_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              word_ev_i,
   input  logic              trail_ev_i,
   input  logic [HI_W-1:0]   hi_i,
   input  logic [BYTE_W-1:0] lo_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              err_o
);

   logic [WORD_W-1:0] sum_q;
   logic [WORD_W-1:0] diff;
   logic [WORD_W-1:0] hi_ext;
   logic [WORD_W-1:0] lo_ext;
   logic              err_q;

   always_comb begin
      hi_ext = {{(WORD_W-HI_W){1'b0}}, hi_i};
      lo_ext = {{(WORD_W-BYTE_W){1'b0}}, lo_i};
      diff   = sum_q - word_i;
      err_o  = err_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
         err_q <= 1'b0;
      end else if (restart_i) begin
         sum_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (word_ev_i)
            sum_q <= sum_q + hi_ext + lo_ext;
         if (trail_ev_i)
            err_q <= |diff;
      end
   end

endmodule

// File: rtl/tape_wport.sv
module tape_wport
   import tape_loader_pkg::*;
#(
   parameter int MEM_DEPTH = 32768,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart_i,
   input  logic               req_i,
   input  logic [FIELD_W-1:0] field_i,
   input  logic [WORD_W-1:0]  origin_i,
   input  logic [WORD_W-1:0]  data_i,
   output logic               wr_en_o,
   output logic [ADDR_W-1:0]  wr_addr_o,
   output logic [WORD_W-1:0]  wr_data_o,
   output logic               ovf_o
);

   localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(MEM_DEPTH);

   logic [ADDR_W-1:0] addr_c;
   logic              in_range;
   logic              ovf_q;

   always_comb begin
      addr_c   = {field_i, origin_i};
      in_range = ({1'b0, addr_c} < DEPTH_L);
      ovf_o    = ovf_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (restart_i)
         ovf_q <= 1'b0;
      else if (req_i && !in_range)
         ovf_q <= 1'b1;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic              en_q;
         logic [ADDR_W-1:0] addr_q;
         logic [WORD_W-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q   <= 1'b0;
               addr_q <= '0;
               data_q <= '0;
            end else begin
               en_q <= req_i && in_range && !restart_i;
               if (req_i) begin
                  addr_q <= addr_c;
                  data_q <= data_i;
               end
            end
         end
         assign wr_en_o   = en_q;
         assign wr_addr_o = addr_q;
         assign wr_data_o = data_q;
      end else begin : g_comb
         assign wr_en_o   = req_i && in_range;
         assign wr_addr_o = addr_c;
         assign wr_data_o = data_i;
      end
   endgenerate

endmodule

// File: rtl/tape_loader.sv
module tape_loader
   import tape_loader_pkg::*;
#(
   parameter int MEM_DEPTH = 32768,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [7:0]        in_byte,
   output logic              wr_en,
   output logic [14:0]       wr_addr,
   output logic [11:0]       wr_data,
   output logic              done,
   output logic              csum_err,
   output logic              overflow
);

   generate
      if (MEM_DEPTH < 1 || MEM_DEPTH > (1 << ADDR_W)) begin : g_bad_depth
         $error("tape_loader: MEM_DEPTH outside the addressable range");
      end
      if (ADDR_W != 15 || WORD_W != 12 || BYTE_W != 8) begin : g_bad_width
         $error("tape_loader: port widths do not match package widths");
      end
   endgenerate

   logic               ready_q;
   logic               take;
   byte_class_t        cls;
   logic [FIELD_W-1:0] fld;
   logic               word_ev;
   logic               is_org;
   logic               trail_ev;
   logic [WORD_W-1:0]  word;
   logic [HI_W-1:0]    hi;
   logic [BYTE_W-1:0]  lo;
   logic [FIELD_W-1:0] field;
   logic [WORD_W-1:0]  origin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ready_q <= 1'b0;
      else
         ready_q <= 1'b1;
   end

   assign in_ready = ready_q && !restart;
   assign take     = in_valid && in_ready;

   tape_classify u_classify (
      .bval_i (in_byte),
      .cls_o  (cls),
      .fld_o  (fld)
   );

   tape_framer u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (restart),
      .take_i     (take),
      .bval_i     (in_byte),
      .cls_i      (cls),
      .fld_i      (fld),
      .word_ev_o  (word_ev),
      .is_org_o   (is_org),
      .trail_ev_o (trail_ev),
      .word_o     (word),
      .hi_o       (hi),
      .lo_o       (lo),
      .field_o    (field),
      .origin_o   (origin),
      .done_o     (done)
   );

   tape_checksum u_checksum (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (restart),
      .word_ev_i  (word_ev),
      .trail_ev_i (trail_ev),
      .hi_i       (hi),
      .lo_i       (lo),
      .word_i     (word),
      .err_o      (csum_err)
   );

   tape_wport #(
      .MEM_DEPTH (MEM_DEPTH),
      .OUT_REG   (OUT_REG)
   ) u_wport (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .req_i     (word_ev && !is_org),
      .field_i   (field),
      .origin_i  (origin),
      .data_i    (word),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .ovf_o     (overflow)
   );

endmodule

// File: rtl/tape_loader_checker.sv
module tape_loader_checker #(
   parameter int MEM_DEPTH = 32768,
   parameter bit OUT_REG   = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        restart,
   input logic        in_valid,
   input logic        in_ready,
   input logic        wr_en,
   input logic [14:0] wr_addr,
   input logic        done,
   input logic        csum_err,
   input logic        overflow
);

   a_r1_no_ready_in_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> !in_ready);

   a_r10_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < MEM_DEPTH));

   a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(overflow) && !$past(restart)) |-> overflow);

   a_r8_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      csum_err |-> done);

   a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done) && !$past(restart)) |-> done);

   generate
      if (OUT_REG) begin : g_reg_chk
         a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
            $past(done) |-> !wr_en);
         a_r6_write_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> $past(in_valid && in_ready));
      end else begin : g_comb_chk
         a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> !wr_en);
         a_r6_write_with_take: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (in_valid && in_ready));
      end
   endgenerate

endmodule

bind tape_loader tape_loader_checker #(
   .MEM_DEPTH (MEM_DEPTH),
   .OUT_REG   (OUT_REG)
) u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .restart  (restart),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .done     (done),
   .csum_err (csum_err),
   .overflow (overflow)
);

// File: tb/tape_loader_bench.sv
`timescale 1ns/1ps
module tape_loader_bench;

   localparam int DEPTH = 12288;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'd0;
   logic        in_ready;
   logic        wr_en;
   logic [14:0] wr_addr;
   logic [11:0] wr_data;
   logic        done;
   logic        csum_err;
   logic        overflow;

   always #5 clk = ~clk;

   tape_loader #(.MEM_DEPTH(DEPTH), .OUT_REG(1'b1)) u_tape_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_byte  (in_byte),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .done     (done),
      .csum_err (csum_err),
      .overflow (overflow)
   );

   int checks = 0;
   int fails  = 0;

   logic [7:0]  tape [0:255];
   int          tlen;
   int          sum;
   int          exp_addr [0:63];
   int          exp_data [0:63];
   int          exp_n;
   int          log_addr [0:255];
   int          log_data [0:255];
   int          log_n = 0;
   int          log_base;

   always @(negedge clk) begin
      if (rst_n && wr_en && log_n < 256) begin
         log_addr[log_n] = int'(wr_addr);
         log_data[log_n] = int'(wr_data);
         log_n = log_n + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %0o expected %0o", tag, act, expv);
      end
   endtask

   task automatic new_tape();
      tlen = 0; sum = 0; exp_n = 0;
   endtask

   task automatic push(input int b);
      tape[tlen] = 8'(b);
      tlen++;
   endtask

   task automatic push_word(input int w);
      int hi, lo;
      hi = (w >> 6) & 8'o177;
      lo = w & 8'o77;
      push(hi); push(lo);
      sum = (sum + hi + lo) & 12'o7777;
   endtask

   task automatic push_sum(input int w);
      push((w >> 6) & 8'o77);
      push(w & 8'o77);
   endtask

   task automatic expect_wr(input int a, input int d);
      exp_addr[exp_n] = a;
      exp_data[exp_n] = d;
      exp_n++;
   endtask

   task automatic play(input bit chk_ready);
      log_base = log_n;
      for (int k = 0; k < tlen; k++) begin
         in_valid = 1'b1;
         in_byte  = tape[k];
         if (chk_ready) chk(in_ready === 1'b1, "R9 ready while done", int'(in_ready), 1);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic compare_writes(input string tag);
      chk(log_n - log_base == exp_n, tag, log_n - log_base, exp_n);
      for (int k = 0; k < exp_n && k < log_n - log_base; k++) begin
         chk(log_addr[log_base+k] == exp_addr[k], tag, log_addr[log_base+k], exp_addr[k]);
         chk(log_data[log_base+k] == exp_data[k], tag, log_data[log_base+k], exp_data[k]);
      end
   endtask

   task automatic pulse_restart();
      restart = 1'b1;
      in_valid = 1'b1;
      in_byte = 8'o100;
      #1;
      chk(in_ready === 1'b0, "R1 ready low in restart", int'(in_ready), 0);
      @(negedge clk);
      restart = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      chk(done === 1'b0, "R1 done cleared", int'(done), 0);
      chk(csum_err === 1'b0, "R1 err cleared", int'(csum_err), 0);
      chk(overflow === 1'b0, "R1 overflow cleared", int'(overflow), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int org, fld, d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(done === 1'b0, "R1 done after reset", int'(done), 0);
      chk(csum_err === 1'b0, "R1 err after reset", int'(csum_err), 0);
      chk(overflow === 1'b0, "R1 overflow after reset", int'(overflow), 0);
      chk(wr_en === 1'b0, "R1 wr_en after reset", int'(wr_en), 0);
      chk(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);

      // Tape 1: leader (R2), origin (R5), data (R4 R6), field (R7), rubout (R3)
      new_tape();
      push(0); push(8'o200); push(0); push(8'o200);
      push_word(13'o10200);
      org = 12'o200; fld = 0;
      for (int i = 0; i < 16; i++) begin
         if (i == 10) begin
            push_word(13'o10400);
            org = 12'o400;
         end
         d = (i == 0) ? 0 : ((i * 12'o451 + 12'o13) & 12'o7777);
         push_word(d);
         expect_wr(fld * 4096 + org, d);
         org = (org + 1) & 12'o7777;
         if (i == 3) begin
            push(8'o320);
            fld = 2;
         end
         if (i == 6) begin
            push(8'o377); push(8'o200);
         end
      end
      push_sum(sum);
      push(8'o200);
      play(1'b0);
      compare_writes("R6 R7 R3 tape1 writes");
      chk(done === 1'b1, "R8 done after trailer", int'(done), 1);
      chk(csum_err === 1'b0, "R8 good checksum", int'(csum_err), 0);
      chk(overflow === 1'b0, "R10 no overflow in range", int'(overflow), 0);

      // R9 bytes after done are ignored
      new_tape();
      push_word(13'o10300); push_word(12'o5); push_word(12'o6); push_word(12'o7);
      push(8'o200);
      play(1'b1);
      compare_writes("R9 no writes after done");
      chk(done === 1'b1, "R9 done held", int'(done), 1);
      chk(csum_err === 1'b0, "R9 err unchanged", int'(csum_err), 0);

      pulse_restart();

      // Tape 3: origin wrap (R6), field reset by restart (R1), bad checksum (R8)
      new_tape();
      push(8'o200);
      push_word(13'o17776);
      org = 12'o7776;
      for (int i = 0; i < 4; i++) begin
         d = (i * 12'o1234 + 12'o77) & 12'o7777;
         push_word(d);
         expect_wr(org, d);
         org = (org + 1) & 12'o7777;
      end
      push_sum((sum + 1) & 12'o7777);
      push(8'o200);
      play(1'b0);
      compare_writes("R6 R1 wrap writes");
      chk(done === 1'b1, "R8 done bad tape", int'(done), 1);
      chk(csum_err === 1'b1, "R8 checksum error", int'(csum_err), 1);

      pulse_restart();

      // Tape 4: field 3 set during leader lies beyond depth (R10, R7)
      new_tape();
      push(8'o200);
      push(8'o330);
      push(0);
      push_word(13'o10100);
      push_word(12'o5);
      push_word(12'o4321);
      push_sum(sum);
      push(8'o200);
      play(1'b0);
      compare_writes("R10 suppressed writes");
      chk(overflow === 1'b1, "R10 overflow set", int'(overflow), 1);
      chk(csum_err === 1'b0, "R8 good checksum tape4", int'(csum_err), 0);
      chk(done === 1'b1, "R8 done tape4", int'(done), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule